// File: doc/BRIEF.md
# Floppy Controller Register Interface

This block is the host-facing register file of a floppy disk controller. A host reaches it over a simple single-cycle bus with an 8-bit offset, an 8-bit write byte and an 8-bit read byte. Read data is combinational in the cycle that `bus_rd` is high. Any side effect of a read, such as clearing a register, takes place at the clock edge that ends that cycle.

The block holds plain configuration registers: setup, gap, first sector, sector count and interrupt mask. It also holds a four-bit phase register and a mode register. The mode register has no plain write port: one offset sets bits and another clears them. Two registers clear on read: an error register and an interrupt-flag register. The stepping and sector-transfer engines outside this block feed those two registers through one-cycle set pulses. They also load the current track and sector bytes.

The block forms a registered, level interrupt from the flags and the mask. It also drives the phase and strobe lines of one internal drive. From the mode and phase registers it builds the drive's command address and its status address. It returns the drive's single status bit to the host.

Top module: `fdc_regfile`

## Requirements
- R1: After reset the first-sector register (offset 9) reads 0xFF. Every other register reads 0x00, and `irq`, `phase_out` and `drv_cmd_valid` are low.
- R2: Setup (2), gap (8), first sector (9), sector count (10) and interrupt mask (11) store the whole written byte. A read returns the stored byte.
- R3: A write to offset 3 clears each mode bit where the byte has a one. A write to offset 4 sets each mode bit where the byte has a one. A read of offset 3 returns the mode byte.
- R4: A read of the error register (offset 0) returns its value and clears it at that edge. A bit of `err_set` pulsed in the same cycle is still set after the clear. Set pulses accumulate.
- R5: A read of the interrupt-flag register (offset 5) returns all pending flags and clears them at that edge. A bit of `flag_set` pulsed in the same cycle is still set after the clear.
- R6: While mode bit 0 is one, `irq` becomes, one edge later, the OR over the bitwise AND of the flag and mask registers. While mode bit 0 is zero, `irq` holds its value.
- R7: A write to the phase register (offset 1) keeps only bits 3:0. A read returns them in bits 3:0 with zeros above, and `phase_out` mirrors them.
- R8: A phase write with data bit 3 set while mode bit 1 is one raises `drv_cmd_valid` for exactly the next cycle. In that cycle `drv_cmd_addr` = {mode bit 5, data bits 1:0} and `drv_cmd_data` = data bit 2. Other writes raise no command.
- R9: `drv_stat_addr` = {mode bit 5, phase bits 2:0}. A read of offset 4 returns `drv_stat_in` on bits 2 and 3, with all other bits zero, while mode bit 1 is one. Otherwise it returns 0x0C.
- R10: Reads of offsets 12 to 255 return 0x00. Writes to them, and writes to offsets 0, 5, 6 and 7, change no register.
- R11: When `id_load` is high, the track (offset 6) and sector (offset 7) registers take `id_track` and `id_sector`. A read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while `bus_rd` is high |
| flag_set | input | 8 | One-cycle interrupt-flag set pulses from the engines |
| err_set | input | 8 | One-cycle error set pulses from the engines |
| id_load | input | 1 | Load strobe for the track and sector bytes |
| id_track | input | 8 | Track byte to load |
| id_sector | input | 8 | Sector byte to load |
| mode_out | output | 8 | Current mode byte, to the engines |
| irq | output | 1 | Level interrupt |
| phase_out | output | 4 | Phase and strobe lines to the drive |
| drv_cmd_valid | output | 1 | One-cycle drive command pulse |
| drv_cmd_addr | output | 3 | Drive command address |
| drv_cmd_data | output | 1 | Drive command data bit |
| drv_stat_addr | output | 4 | Drive status address |
| drv_stat_in | input | 1 | Drive status bit |

## Verification
Several rules are checked by assertions on every cycle: set pulses that coincide with a read-clear are kept, mode set-writes take effect, `irq` holds while interrupts are disabled, commands come only from a strobed phase write with the drive selected, the handshake bits mirror each other, and unmapped reads return zero. Other behaviour only the bench's scenarios can show. This covers the reset values, the full-byte storage of each configuration register, the exact value of `irq` after enabling, and that writes to read-only or unmapped offsets change nothing. It also covers the status bit that comes back for each status address, which the bench checks by driving `drv_stat_in` from a fixed pattern indexed by `drv_stat_addr`.

// File: rtl/fdc_regfile_pkg.sv
package fdc_regfile_pkg;
   localparam int NUM_OFFS = 12;

   localparam int OFF_ERR    = 0;
   localparam int OFF_PHASE  = 1;
   localparam int OFF_SETUP  = 2;
   localparam int OFF_MCLR   = 3;
   localparam int OFF_MSET   = 4;
   localparam int OFF_IFLAG  = 5;
   localparam int OFF_TRACK  = 6;
   localparam int OFF_SECTOR = 7;
   localparam int OFF_GAP    = 8;
   localparam int OFF_FIRST  = 9;
   localparam int OFF_COUNT  = 10;
   localparam int OFF_MASK   = 11;

   // offsets that accept a host write
   localparam logic [NUM_OFFS-1:0] WRITABLE = 12'b1111_0001_1110;

   typedef struct packed {
      logic       valid;
      logic [2:0] addr;
      logic       data;
   } drv_cmd_t;
endpackage

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode #(
   parameter int ADDR_W = 8,
   parameter int NOFF   = 12,
   parameter logic [NOFF-1:0] WR_OK = '1
) (
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output logic [NOFF-1:0]   wr_sel,
   output logic [NOFF-1:0]   rd_sel
);
   for (genvar i = 0; i < NOFF; i++) begin : g_off
      logic hit;
      assign hit = (addr == ADDR_W'(i));
      assign rd_sel[i] = rd & hit;
      if (WR_OK[i]) begin : g_w
         assign wr_sel[i] = wr & hit;
      end else begin : g_nw
         assign wr_sel[i] = 1'b0;
      end
   end
endmodule

// File: rtl/fdc_flag_bank.sv
module fdc_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] set,
   output logic [W-1:0] q
);
   // each bit is a sticky cell: set wins over a same-cycle clear
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[b] <= 1'b0;
         else if (set[b]) q[b] <= 1'b1;
         else if (clr)    q[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/fdc_irq_gen.sv
module fdc_irq_gen #(
   parameter int W    = 8,
   parameter bit HOLD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] flags,
   input  logic [W-1:0] mask,
   output logic         irq
);
   logic pend;
   assign pend = |(flags & mask);

   if (HOLD) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  irq <= 1'b0;
         else if (en) irq <= pend;
      end
   end else begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= en & pend;
      end
   end
endmodule

// File: rtl/fdc_drive_port.sv
module fdc_drive_port
   import fdc_regfile_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       phase_wr,
   input  logic [3:0] wnib,
   input  logic       drv_sel,
   input  logic       side,
   input  logic [3:0] phase_q,
   input  logic       stat_in,
   output drv_cmd_t   cmd,
   output logic [3:0] stat_addr,
   output logic [7:0] hs_byte
);
   logic strobe;
   assign strobe = phase_wr & wnib[3] & drv_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= '0;
      end else begin
         cmd.valid <= strobe;
         if (strobe) begin
            cmd.addr <= {side, wnib[1:0]};
            cmd.data <= wnib[2];
         end
      end
   end

   assign stat_addr = {side, phase_q[2:0]};
   assign hs_byte   = drv_sel ? {4'b0, stat_in, stat_in, 2'b0} : 8'h0C;
endmodule

// File: rtl/fdc_regfile.sv
module fdc_regfile
   import fdc_regfile_pkg::*;
#(
   parameter int   ADDR_W        = 8,
   parameter int   FLAG_W        = 8,
   parameter logic [7:0] FIRST_RST = 8'hFF,
   parameter int   IEN_BIT       = 0,
   parameter int   DSEL_BIT      = 1,
   parameter int   SIDE_BIT      = 5,
   parameter bit   IRQ_HOLD      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [FLAG_W-1:0] flag_set,
   input  logic [FLAG_W-1:0] err_set,
   input  logic              id_load,
   input  logic [7:0]        id_track,
   input  logic [7:0]        id_sector,
   output logic [7:0]        mode_out,
   output logic              irq,
   output logic [3:0]        phase_out,
   output logic              drv_cmd_valid,
   output logic [2:0]        drv_cmd_addr,
   output logic              drv_cmd_data,
   output logic [3:0]        drv_stat_addr,
   input  logic              drv_stat_in
);
   if (FLAG_W < 1 || FLAG_W > 8) begin : g_bad_fw
      $error("FLAG_W must lie in 1..8");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("ADDR_W too small for the register map");
   end
   if (IEN_BIT > 7 || DSEL_BIT > 7 || SIDE_BIT > 7) begin : g_bad_bit
      $error("mode bit index out of range");
   end

   logic [NUM_OFFS-1:0] wr_sel, rd_sel;
   logic [7:0] mode_q, setup_q, gap_q, first_q, count_q, track_q, sector_q;
   logic [3:0] phase_q;
   logic [FLAG_W-1:0] mask_q, flags_q, err_q;
   logic [7:0] hs_byte;
   drv_cmd_t   cmd;

   fdc_addr_decode #(.ADDR_W(ADDR_W), .NOFF(NUM_OFFS), .WR_OK(WRITABLE)) u_dec (
      .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wr_sel(wr_sel), .rd_sel(rd_sel));

   fdc_flag_bank #(.W(FLAG_W)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(rd_sel[OFF_ERR]), .set(err_set), .q(err_q));

   fdc_flag_bank #(.W(FLAG_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(rd_sel[OFF_IFLAG]), .set(flag_set), .q(flags_q));

   fdc_irq_gen #(.W(FLAG_W), .HOLD(IRQ_HOLD)) u_irq (
      .clk(clk), .rst_n(rst_n), .en(mode_q[IEN_BIT]), .flags(flags_q),
      .mask(mask_q), .irq(irq));

   fdc_drive_port u_drv (
      .clk(clk), .rst_n(rst_n), .phase_wr(wr_sel[OFF_PHASE]), .wnib(bus_wdata[3:0]),
      .drv_sel(mode_q[DSEL_BIT]), .side(mode_q[SIDE_BIT]), .phase_q(phase_q),
      .stat_in(drv_stat_in), .cmd(cmd), .stat_addr(drv_stat_addr), .hs_byte(hs_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         setup_q <= '0;
         gap_q   <= '0;
         first_q <= FIRST_RST;
         count_q <= '0;
         mask_q  <= '0;
         phase_q <= '0;
      end else begin
         if (wr_sel[OFF_MCLR])  mode_q  <= mode_q & ~bus_wdata;
         if (wr_sel[OFF_MSET])  mode_q  <= mode_q | bus_wdata;
         if (wr_sel[OFF_SETUP]) setup_q <= bus_wdata;
         if (wr_sel[OFF_GAP])   gap_q   <= bus_wdata;
         if (wr_sel[OFF_FIRST]) first_q <= bus_wdata;
         if (wr_sel[OFF_COUNT]) count_q <= bus_wdata;
         if (wr_sel[OFF_MASK])  mask_q  <= bus_wdata[FLAG_W-1:0];
         if (wr_sel[OFF_PHASE]) phase_q <= bus_wdata[3:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         track_q  <= '0;
         sector_q <= '0;
      end else if (id_load) begin
         track_q  <= id_track;
         sector_q <= id_sector;
      end
   end

   // read view per offset; a one-hot select picks the entry
   logic [7:0] view [NUM_OFFS];
   always_comb begin
      view[OFF_ERR]    = 8'(err_q);
      view[OFF_PHASE]  = {4'b0, phase_q};
      view[OFF_SETUP]  = setup_q;
      view[OFF_MCLR]   = mode_q;
      view[OFF_MSET]   = hs_byte;
      view[OFF_IFLAG]  = 8'(flags_q);
      view[OFF_TRACK]  = track_q;
      view[OFF_SECTOR] = sector_q;
      view[OFF_GAP]    = gap_q;
      view[OFF_FIRST]  = first_q;
      view[OFF_COUNT]  = count_q;
      view[OFF_MASK]   = 8'(mask_q);
      bus_rdata = '0;
      for (int i = 0; i < NUM_OFFS; i++)
         if (rd_sel[i]) bus_rdata = bus_rdata | view[i];
   end

   assign mode_out      = mode_q;
   assign phase_out     = phase_q;
   assign drv_cmd_valid = cmd.valid;
   assign drv_cmd_addr  = cmd.addr;
   assign drv_cmd_data  = cmd.data;
endmodule

// File: rtl/fdc_regfile_chk.sv
module fdc_regfile_chk #(
   parameter int ADDR_W = 8,
   parameter int FLAG_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [FLAG_W-1:0] flag_set,
   input logic [FLAG_W-1:0] err_set,
   input logic [FLAG_W-1:0] flags_q,
   input logic [FLAG_W-1:0] err_q,
   input logic [7:0]        mode_out,
   input logic              irq,
   input logic              drv_cmd_valid,
   input logic [2:0]        drv_cmd_addr
);
   a_r5_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != '0) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

   a_r4_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));

   a_r4_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(0) && err_set == '0) |=> (err_q == '0));

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(4)) |=> ((mode_out & $past(bus_wdata)) == $past(bus_wdata)));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_out[0] |=> $stable(irq));

   a_r8_cmd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      drv_cmd_valid |-> $past(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[3] && mode_out[1]));

   a_r8_cmd_addr: assert property (@(posedge clk) disable iff (!rst_n)
      drv_cmd_valid |-> (drv_cmd_addr == {$past(mode_out[5]), $past(bus_wdata[1:0])}));

   a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(4)) |-> (bus_rdata[3] == bus_rdata[2]));

   a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= ADDR_W'(12)) |-> (bus_rdata == 8'h00));
endmodule

bind fdc_regfile fdc_regfile_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_set(flag_set), .err_set(err_set),
   .flags_q(flags_q), .err_q(err_q), .mode_out(mode_out), .irq(irq),
   .drv_cmd_valid(drv_cmd_valid), .drv_cmd_addr(drv_cmd_addr));

// File: tb/fdc_regfile_test.sv
module fdc_regfile_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0, id_load = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0, id_track = 0, id_sector = 0;
   logic [7:0] flag_set = 0, err_set = 0;
   logic [7:0] bus_rdata, mode_out;
   logic irq, drv_cmd_valid, drv_cmd_data, drv_stat_in;
   logic [3:0] phase_out, drv_stat_addr;
   logic [2:0] drv_cmd_addr;

   localparam logic [15:0] STAT_PAT = 16'hA5C3;
   assign drv_stat_in = STAT_PAT[drv_stat_addr];

   always #2 clk = ~clk;   // 250 MHz

   fdc_regfile uut (.*);

   int tests = 0, fails = 0;
   logic [7:0] m_mode, m_setup, m_gap, m_first, m_cnt, m_mask, m_err, m_flags, m_trk, m_sec;
   logic [3:0] m_phase;
   logic m_irq, m_cv, m_cd;
   logic [2:0] m_ca;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      logic s;
      s = STAT_PAT[{m_mode[5], m_phase[2:0]}];
      case (a)
         0: return m_err;
         1: return {4'b0, m_phase};
         2: return m_setup;
         3: return m_mode;
         4: return m_mode[1] ? {4'b0, s, s, 2'b0} : 8'h0C;
         5: return m_flags;
         6: return m_trk;
         7: return m_sec;
         8: return m_gap;
         9: return m_first;
         10: return m_cnt;
         11: return m_mask;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string req_of(logic [7:0] a);
      case (a)
         0: return "R4";  1: return "R7";  3: return "R3";  4: return "R9";
         5: return "R5";  6, 7: return "R11";
         2, 8, 9, 10, 11: return "R2";
         default: return "R10";
      endcase
   endfunction

   task automatic model_reset();
      m_mode = 0; m_setup = 0; m_gap = 0; m_first = 8'hFF; m_cnt = 0; m_mask = 0;
      m_err = 0; m_flags = 0; m_trk = 0; m_sec = 0; m_phase = 0;
      m_irq = 0; m_cv = 0; m_cd = 0; m_ca = 0;
   endtask

   // one bus cycle: drive at negedge, check just before the edge, advance model
   task automatic op(logic wr, logic rd, logic [7:0] a, logic [7:0] d,
                     logic [7:0] fs, logic [7:0] es, logic ld, logic [7:0] t, logic [7:0] s);
      logic [7:0] n_mode, n_err, n_flags;
      logic n_irq, n_cv;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      flag_set = fs; err_set = es; id_load = ld; id_track = t; id_sector = s;
      #1;
      if (rd) chk(req_of(a), bus_rdata, exp_rd(a));
      chk("R6", irq, m_irq);
      chk("R7", phase_out, m_phase);
      chk("R9", drv_stat_addr, {m_mode[5], m_phase[2:0]});
      chk("R8", drv_cmd_valid, m_cv);
      if (m_cv) begin
         chk("R8", drv_cmd_addr, m_ca);
         chk("R8", drv_cmd_data, m_cd);
      end
      chk("R3", mode_out, m_mode);
      n_irq   = m_mode[0] ? |(m_flags & m_mask) : m_irq;
      n_err   = ((rd && a == 0) ? 8'h00 : m_err) | es;
      n_flags = ((rd && a == 5) ? 8'h00 : m_flags) | fs;
      n_mode  = m_mode;
      n_cv    = wr && a == 1 && d[3] && m_mode[1];
      if (n_cv) begin m_ca = {m_mode[5], d[1:0]}; m_cd = d[2]; end
      if (wr) case (a)
         1: m_phase = d[3:0];
         2: m_setup = d;
         3: n_mode = m_mode & ~d;
         4: n_mode = m_mode | d;
         8: m_gap = d;
         9: m_first = d;
         10: m_cnt = d;
         11: m_mask = d;
         default: ;
      endcase
      if (ld) begin m_trk = t; m_sec = s; end
      m_mode = n_mode; m_err = n_err; m_flags = n_flags; m_irq = n_irq; m_cv = n_cv;
   endtask

   task automatic wr_reg(logic [7:0] a, logic [7:0] d); op(1, 0, a, d, 0, 0, 0, 0, 0); endtask
   task automatic rd_reg(logic [7:0] a);                op(0, 1, a, 0, 0, 0, 0, 0, 0); endtask
   task automatic idle();                               op(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

   initial begin : watchdog
      #400000;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int seed = 32'h5EED;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset values of every mapped offset
      for (int a = 0; a < 12; a++) begin
         @(negedge clk); bus_rd = 1; bus_addr = 8'(a); #1;
         chk("R1", bus_rdata, (a == 9) ? 8'hFF : (a == 4 ? 8'h0C : 8'h00));
      end
      @(negedge clk); bus_rd = 0; #1;
      chk("R1", {irq, phase_out, drv_cmd_valid}, 0);

      // R3 directed: set then clear
      wr_reg(4, 8'hA3); rd_reg(3); wr_reg(3, 8'h21); rd_reg(3);
      // R8 directed: strobe with drive selected (mode bit1 set), side bit 5
      wr_reg(4, 8'h22); wr_reg(1, 8'h0E); idle(); wr_reg(1, 8'h07); idle();
      // R9: status through each phase value
      for (int p = 0; p < 8; p++) begin wr_reg(1, 8'(p)); rd_reg(4); end
      wr_reg(3, 8'h02); wr_reg(1, 8'h0F); rd_reg(4); idle();
      // R5/R6: flag read with simultaneous pulse, irq enable and hold
      wr_reg(11, 8'h0F); op(0, 0, 0, 0, 8'h04, 8'h10, 0, 0, 0); idle(); idle();
      wr_reg(4, 8'h01); idle(); idle();
      op(0, 1, 5, 0, 8'h01, 0, 0, 0, 0); rd_reg(5); idle(); idle();
      wr_reg(3, 8'h01); op(0, 0, 0, 0, 8'h02, 0, 0, 0, 0); idle(); idle();
      // R4: error read clear with simultaneous set
      op(0, 1, 0, 0, 0, 8'h80, 0, 0, 0); rd_reg(0); rd_reg(0);
      // R10/R11: ignored writes and id load
      wr_reg(6, 8'h55); wr_reg(7, 8'h66); wr_reg(200, 8'hFF); wr_reg(0, 8'hFF); wr_reg(5, 8'hFF);
      rd_reg(6); rd_reg(0); rd_reg(5); rd_reg(255); rd_reg(12);
      op(0, 0, 0, 0, 0, 0, 1, 8'h93, 8'h8A); rd_reg(6); rd_reg(7);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] a, d, fs, es;
         logic wr, rd;
         a  = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 12);
         d  = 8'($urandom);
         wr = ($urandom % 2) == 0;
         rd = !wr && ($urandom % 3 != 0);
         fs = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         es = ($urandom % 9 == 0) ? 8'($urandom) : 8'h00;
         op(wr, rd, a, d, fs, es, ($urandom % 10 == 0), 8'($urandom), 8'($urandom));
      end
      idle();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule